// File: doc/BRIEF.md
# Low-Frequency Independent Watchdog

This block is a watchdog timer clocked from a free-running slow clock. Because it uses no system clock, it keeps counting while the rest of the chip sleeps or is stopped. A power-of-two prescaler sets the rate at which an 8-bit down counter steps. When the count passes zero, the block either pulses a reset request or latches an interrupt flag, as configuration selects. The counter then reloads to all ones.

Two programmable thresholds give software warnings before the counter runs out. Each threshold latches its own interrupt flag when the count steps onto that value. Software then has time to wake up and refresh. A refresh is accepted only when a fixed key value is written. Configuration and thresholds can be frozen with a lock bit, which only a block reset releases.

All access goes through a single write port with four addresses: configuration, thresholds, refresh key and flag clear. The current count is brought out for observation.

Top module: `lfclk_watchdog`

## Requirements
- R1: After reset the count is 0xFF, the block is disabled and unlocked, both thresholds are 0xFF, and the reset request and all interrupt outputs are low.
- R2: While the block is enabled, the count decreases by one every 2^n clocks. Here n is configuration bits [3:0] (address 0), and any value above 12 acts as 12. The first step comes 2^n clocks after the enabling write.
- R3: With configuration bit 4 set (reset action), a step taken while the count is 0x00 produces a reset request for exactly one clock, starting the clock after that step. The count reloads to 0xFF in the same step and keeps running.
- R4: With configuration bit 4 clear (interrupt action), the same step sets the underflow interrupt instead, with no reset request. The interrupt stays high until cleared, and the count wraps to 0xFF and keeps running.
- R5: Writing 0xA5C3 to address 2 reloads the count to 0xFF and restarts the prescaler from zero. Any other value written there has no effect.
- R6: A valid refresh that lands in the same clock as an underflow step wins: the count becomes 0xFF and neither the reset request nor the underflow interrupt is raised.
- R7: Address 1 holds threshold 0 in bits [7:0] and threshold 1 in bits [15:8]. When a step makes the count equal a threshold, that threshold's warning interrupt sets and stays set until cleared. A threshold of 0xFF never fires, so each warning fires at most once per countdown pass.
- R8: Writing to address 3 clears interrupts by writing ones: bit 0 clears underflow, bit 1 clears warning 0, and bit 2 clears warning 1. A flag that sets in the same clock as its clear stays set.
- R9: Writing configuration with bit 6 set locks the block. After that, writes to addresses 0 and 1 are ignored until the block is reset.
- R10: Configuration bit 5 enables counting. While it is clear the count holds, although a refresh still reloads it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running low-frequency clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Register select: 0 config, 1 thresholds, 2 refresh key, 3 flag clear |
| wr_data | input | 16 | Write data |
| rst_req | output | 1 | One-clock reset request on underflow in reset mode |
| irq_underflow | output | 1 | Sticky underflow interrupt in interrupt mode |
| irq_warn | output | 2 | Sticky early-warning interrupts, one per threshold |
| count | output | 8 | Current counter value |

## Verification
Two pairs of events can fall in the same clock. The first pair is a refresh and an underflow step. The bench lets the count reach 0x00 and then writes the key on the very edge that would underflow. It expects the count to be 0xFF with no reset pulse on the next clock and none afterwards. The second pair is a flag clear and a warning set. The bench writes the clear for warning 0 on the edge where the count steps onto threshold 0, and expects the warning to remain high until a later clear removes it.

// File: rtl/lfclk_watchdog_pkg.sv
package lfclk_watchdog_pkg;

   // register select codes on the write port
   typedef enum logic [1:0] {
      ADR_CFG = 2'd0,
      ADR_THR = 2'd1,
      ADR_KEY = 2'd2,
      ADR_CLR = 2'd3
   } wd_addr_e;

   // configuration word layout
   localparam int PSEL_W       = 4;
   localparam int CFG_ACT_BIT  = 4;
   localparam int CFG_EN_BIT   = 5;
   localparam int CFG_LOCK_BIT = 6;

   typedef struct packed {
      logic              lock;
      logic              en;
      logic              act_rst;
      logic [PSEL_W-1:0] psel;
   } wd_cfg_t;

endpackage

// File: rtl/lfwd_regs.sv
module lfwd_regs
   import lfclk_watchdog_pkg::*;
#(
   parameter int          CNT_W  = 8,
   parameter int          DATA_W = 16,
   parameter int          N_WARN = 2,
   parameter logic [15:0] KEY    = 16'hA5C3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [1:0]              wr_addr,
   input  logic [DATA_W-1:0]       wr_data,
   output wd_cfg_t                 cfg,
   output logic [N_WARN*CNT_W-1:0] thr_flat,
   output logic                    refresh,
   output logic [N_WARN:0]         clr
);
   localparam int THR_W = N_WARN * CNT_W;

   logic cfg_wr, thr_wr;

   assign cfg_wr  = wr_en && (wr_addr == ADR_CFG) && !cfg.lock;
   assign thr_wr  = wr_en && (wr_addr == ADR_THR) && !cfg.lock;
   assign refresh = wr_en && (wr_addr == ADR_KEY) && (wr_data[15:0] == KEY);
   assign clr     = (wr_en && (wr_addr == ADR_CLR)) ? wr_data[N_WARN:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (cfg_wr) begin
         cfg.psel    <= wr_data[PSEL_W-1:0];
         cfg.act_rst <= wr_data[CFG_ACT_BIT];
         cfg.en      <= wr_data[CFG_EN_BIT];
         cfg.lock    <= wr_data[CFG_LOCK_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_flat <= '1;
      end else if (thr_wr) begin
         thr_flat <= wr_data[THR_W-1:0];
      end
   end

   generate
      if (DATA_W > 16) begin : g_wide
         logic unused_hi;
         assign unused_hi = ^wr_data[DATA_W-1:16];
      end
   endgenerate

endmodule

// File: rtl/lfwd_prescaler.sv
module lfwd_prescaler #(
   parameter int PRE_W  = 12,
   parameter int PSEL_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              restart,
   input  logic [PSEL_W-1:0] psel,
   output logic              tick
);
   logic [PRE_W-1:0] pre_q;
   logic [PSEL_W-1:0] n_eff;
   logic [PRE_W:0]    one_sh;
   logic [PRE_W-1:0]  mask;

   // selections above the stage depth saturate at full division
   assign n_eff  = (psel > PSEL_W'(PRE_W)) ? PSEL_W'(PRE_W) : psel;
   assign one_sh = (PRE_W+1)'(1) << n_eff;
   assign mask   = one_sh[PRE_W-1:0] - PRE_W'(1);
   assign tick   = en && ((pre_q & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
      end else if (restart) begin
         pre_q <= '0;
      end else if (en) begin
         pre_q <= pre_q + PRE_W'(1);
      end
   end

endmodule

// File: rtl/lfwd_counter.sv
module lfwd_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             reload,
   output logic [CNT_W-1:0] cnt,
   output logic             underflow,
   output logic             step_dn
);
   localparam logic [CNT_W-1:0] TOP = '1;

   logic at_zero;

   assign at_zero   = (cnt == '0);
   assign underflow = tick && !reload && at_zero;
   assign step_dn   = tick && !reload && !at_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= TOP;
      end else if (reload || underflow) begin
         cnt <= TOP;
      end else if (step_dn) begin
         cnt <= cnt - CNT_W'(1);
      end
   end

endmodule

// File: rtl/lfwd_warn_cmp.sv
module lfwd_warn_cmp #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_dn,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] thr,
   input  logic             clr,
   output logic             flag
);
   logic hit;

   // compare the value the counter is about to take
   assign hit = step_dn && ((cnt - CNT_W'(1)) == thr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
      end else begin
         flag <= (flag && !clr) || hit;
      end
   end

endmodule

// File: rtl/lfclk_watchdog.sv
module lfclk_watchdog
   import lfclk_watchdog_pkg::*;
#(
   parameter int          CNT_W  = 8,
   parameter int          PRE_W  = 12,
   parameter int          DATA_W = 16,
   parameter int          N_WARN = 2,
   parameter logic [15:0] KEY    = 16'hA5C3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              rst_req,
   output logic              irq_underflow,
   output logic [N_WARN-1:0] irq_warn,
   output logic [CNT_W-1:0]  count
);
   localparam int THR_W = N_WARN * CNT_W;

   generate
      if (DATA_W < 16) begin : g_chk_data
         $error("DATA_W must hold the 16-bit refresh key");
      end
      if (THR_W > DATA_W) begin : g_chk_thr
         $error("thresholds do not fit in one write word");
      end
      if (N_WARN < 1 || N_WARN + 1 > DATA_W) begin : g_chk_warn
         $error("N_WARN out of range");
      end
      if (PRE_W < 1 || $clog2(PRE_W + 1) > PSEL_W) begin : g_chk_pre
         $error("PRE_W not selectable by the psel field");
      end
      if (CNT_W < 2) begin : g_chk_cnt
         $error("CNT_W too small");
      end
   endgenerate

   wd_cfg_t            cfg;
   logic [THR_W-1:0]   thr_flat;
   logic               refresh;
   logic [N_WARN:0]    clr;
   logic               tick, underflow, step_dn;
   logic               cfg_en, cfg_act, cfg_lock;

   assign cfg_en   = cfg.en;
   assign cfg_act  = cfg.act_rst;
   assign cfg_lock = cfg.lock;

   lfwd_regs #(
      .CNT_W (CNT_W),
      .DATA_W(DATA_W),
      .N_WARN(N_WARN),
      .KEY   (KEY)
   ) regs_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .cfg     (cfg),
      .thr_flat(thr_flat),
      .refresh (refresh),
      .clr     (clr)
   );

   lfwd_prescaler #(
      .PRE_W (PRE_W),
      .PSEL_W(PSEL_W)
   ) pre_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (cfg.en),
      .restart(refresh),
      .psel   (cfg.psel),
      .tick   (tick)
   );

   lfwd_counter #(
      .CNT_W(CNT_W)
   ) cnt_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .reload   (refresh),
      .cnt      (count),
      .underflow(underflow),
      .step_dn  (step_dn)
   );

   generate
      for (genvar w = 0; w < N_WARN; w++) begin : g_warn
         lfwd_warn_cmp #(
            .CNT_W(CNT_W)
         ) cmp_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .step_dn(step_dn),
            .cnt    (count),
            .thr    (thr_flat[w*CNT_W +: CNT_W]),
            .clr    (clr[w+1]),
            .flag   (irq_warn[w])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_req       <= 1'b0;
         irq_underflow <= 1'b0;
      end else begin
         rst_req       <= underflow && cfg.act_rst;
         irq_underflow <= (irq_underflow && !clr[0]) || (underflow && !cfg.act_rst);
      end
   end

endmodule

// File: rtl/lfclk_watchdog_chk.sv
module lfclk_watchdog_chk #(
   parameter int CNT_W  = 8,
   parameter int N_WARN = 2
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    rst_req,
   input logic                    irq_underflow,
   input logic [N_WARN-1:0]       irq_warn,
   input logic [CNT_W-1:0]        count,
   input logic                    cfg_en,
   input logic                    cfg_act,
   input logic                    cfg_lock,
   input logic [N_WARN*CNT_W-1:0] thr_flat
);
   localparam logic [CNT_W-1:0] TOP = '1;

   assert_rst_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   assert_rst_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> (count == TOP) && ($past(count) == '0) && $past(cfg_act));

   assert_irq_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_underflow) |-> !$past(cfg_act) && (count == TOP));

   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (count != $past(count)) |-> (count == CNT_W'($past(count) - CNT_W'(1))) || (count == TOP));

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cfg_en) |-> (count == $past(count)) || (count == TOP));

   assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_lock) |-> cfg_lock);

   assert_lock_thr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_lock) |-> $stable(thr_flat));

   generate
      for (genvar w = 0; w < N_WARN; w++) begin : g_w
         assert_warn_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_warn[w]) |-> (count == $past(thr_flat[w*CNT_W +: CNT_W])));
      end
   endgenerate

endmodule

bind lfclk_watchdog lfclk_watchdog_chk #(
   .CNT_W (CNT_W),
   .N_WARN(N_WARN)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .rst_req      (rst_req),
   .irq_underflow(irq_underflow),
   .irq_warn     (irq_warn),
   .count        (count),
   .cfg_en       (cfg_en),
   .cfg_act      (cfg_act),
   .cfg_lock     (cfg_lock),
   .thr_flat     (thr_flat)
);

// File: tb/lfclk_watchdog_tb_top.sv
module lfclk_watchdog_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [15:0] KEY = 16'hA5C3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = 2'd0;
   logic [15:0] wr_data = 16'd0;
   logic        rst_req, irq_underflow;
   logic [1:0]  irq_warn;
   logic [7:0]  count;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lfclk_watchdog dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_addr      (wr_addr),
      .wr_data      (wr_data),
      .rst_req      (rst_req),
      .irq_underflow(irq_underflow),
      .irq_warn     (irq_warn),
      .count        (count)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      wr_en = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // drive at a falling edge; the write takes effect at the next rising edge
   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      wr_en   = 1'b1;
      wr_addr = a;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 count", 16'(count), 16'h00FF);
      chk("R1 rst_req", 16'(rst_req), 16'h0);
      chk("R1 irqs", 16'({irq_warn, irq_underflow}), 16'h0);
      wait_n(20);
      chk("R1 disabled hold", 16'(count), 16'h00FF);
   endtask

   task automatic t_rate();
      do_reset();
      wr(2'd0, 16'h0020);
      wait_n(10);
      chk("R2 n=0 rate", 16'(count), 16'h00F5);
      do_reset();
      wr(2'd0, 16'h0023);
      wait_n(7);
      chk("R2 n=3 before step", 16'(count), 16'h00FF);
      wait_n(1);
      chk("R2 n=3 step", 16'(count), 16'h00FE);
      do_reset();
      wr(2'd0, 16'h002F);
      wait_n(4095);
      chk("R2 clamp before step", 16'(count), 16'h00FF);
      wait_n(1);
      chk("R2 clamp step", 16'(count), 16'h00FE);
   endtask

   task automatic t_enable();
      do_reset();
      wr(2'd0, 16'h0020);
      wait_n(5);
      chk("R10 running", 16'(count), 16'h00FA);
      wr(2'd0, 16'h0000);
      chk("R10 last step", 16'(count), 16'h00F9);
      wait_n(10);
      chk("R10 hold", 16'(count), 16'h00F9);
      wr(2'd2, KEY);
      chk("R10 refresh while off", 16'(count), 16'h00FF);
   endtask

   task automatic t_reset_mode();
      do_reset();
      wr(2'd0, 16'h0030);
      wait_n(255);
      chk("R3 at zero", 16'(count), 16'h0000);
      chk("R3 no early req", 16'(rst_req), 16'h0);
      wait_n(1);
      chk("R3 req pulse", 16'(rst_req), 16'h1);
      chk("R3 reload", 16'(count), 16'h00FF);
      wait_n(1);
      chk("R3 req ends", 16'(rst_req), 16'h0);
      chk("R3 keeps running", 16'(count), 16'h00FE);
      chk("R3 no irq", 16'(irq_underflow), 16'h0);
   endtask

   task automatic t_irq_mode();
      do_reset();
      wr(2'd0, 16'h0020);
      wait_n(256);
      chk("R4 irq set", 16'(irq_underflow), 16'h1);
      chk("R4 no req", 16'(rst_req), 16'h0);
      chk("R4 wrap", 16'(count), 16'h00FF);
      wait_n(5);
      chk("R4 sticky", 16'(irq_underflow), 16'h1);
      chk("R4 running", 16'(count), 16'h00FA);
      wr(2'd3, 16'h0006);
      chk("R8 other bits leave underflow", 16'(irq_underflow), 16'h1);
      wr(2'd3, 16'h0001);
      chk("R8 clear underflow", 16'(irq_underflow), 16'h0);
   endtask

   task automatic t_refresh();
      do_reset();
      wr(2'd0, 16'h0020);
      wait_n(20);
      chk("R5 before", 16'(count), 16'h00EB);
      wr(2'd2, KEY);
      chk("R5 reload", 16'(count), 16'h00FF);
      wr(2'd2, 16'h1234);
      chk("R5 bad key ignored", 16'(count), 16'h00FE);
      do_reset();
      wr(2'd0, 16'h0022);
      wait_n(3);
      wr(2'd2, KEY);
      chk("R5 reload on tick", 16'(count), 16'h00FF);
      wait_n(3);
      chk("R5 prescaler restarted", 16'(count), 16'h00FF);
      wait_n(1);
      chk("R5 step after restart", 16'(count), 16'h00FE);
   endtask

   task automatic t_refresh_vs_uf();
      do_reset();
      wr(2'd0, 16'h0030);
      wait_n(255);
      chk("R6 at zero", 16'(count), 16'h0000);
      wr(2'd2, KEY);
      chk("R6 refresh wins", 16'(count), 16'h00FF);
      chk("R6 no req", 16'(rst_req), 16'h0);
      wait_n(1);
      chk("R6 still no req", 16'(rst_req), 16'h0);
      chk("R6 running", 16'(count), 16'h00FE);
   endtask

   task automatic t_warn();
      do_reset();
      wr(2'd1, 16'h4080);
      wr(2'd0, 16'h0020);
      wait_n(126);
      chk("R7 w0 not yet", 16'(irq_warn), 16'h0);
      wait_n(1);
      chk("R7 w0 set", 16'(irq_warn), 16'h1);
      wait_n(63);
      chk("R7 w1 not yet", 16'(irq_warn), 16'h1);
      wait_n(1);
      chk("R7 both set", 16'(irq_warn), 16'h3);
      wr(2'd3, 16'h0004);
      chk("R8 clear w1 only", 16'(irq_warn), 16'h1);
      wr(2'd3, 16'h0002);
      chk("R8 clear w0", 16'(irq_warn), 16'h0);
      wait_n(100);
      chk("R7 once per pass", 16'(irq_warn), 16'h0);
   endtask

   task automatic t_set_wins();
      do_reset();
      wr(2'd1, 16'hFF80);
      wr(2'd0, 16'h0020);
      wait_n(126);
      chk("R8 at 0x81", 16'(count), 16'h0081);
      wr(2'd3, 16'h0002);
      chk("R8 set beats clear", 16'(irq_warn), 16'h1);
      wr(2'd3, 16'h0002);
      chk("R8 later clear", 16'(irq_warn), 16'h0);
      wait_n(200);
      chk("R7 threshold FF silent", 16'(irq_warn), 16'h0);
   endtask

   task automatic t_lock();
      do_reset();
      wr(2'd0, 16'h0060);
      wr(2'd1, 16'h10F0);
      wr(2'd0, 16'h0023);
      chk("R9 config ignored", 16'(count), 16'h00FD);
      wait_n(3);
      chk("R9 rate unchanged", 16'(count), 16'h00FA);
      wait_n(240);
      chk("R9 thresholds ignored", 16'(irq_warn), 16'h0);
      wr(2'd2, KEY);
      chk("R9 refresh still works", 16'(count), 16'h00FF);
      do_reset();
      wr(2'd0, 16'h0023);
      wait_n(8);
      chk("R9 reset unlocks", 16'(count), 16'h00FE);
   endtask

   initial begin
      t_reset();
      t_rate();
      t_enable();
      t_reset_mode();
      t_irq_mode();
      t_refresh();
      t_refresh_vs_uf();
      t_warn();
      t_set_wins();
      t_lock();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule